// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block collects the interrupt-worthy events of a CAN controller and turns them into sticky flags and four request lines: wake-up, error, receive and transmit. The event sources are the controller's three transmit buffers, its receive FIFO, the sleep-mode wake-up detector, the FIFO overrun detector, and the transmit and receive error counters. The block does not do the counting itself. It sorts each counter value into a health range and raises a status-change flag when either counter moves into a different range.

Software sees the unit through a small register port with four 8-bit locations. The event flags are cleared by writing one to their bits, and writing zero leaves them alone. A second location holds the per-source local enables and a global mask. The transmit-empty flags follow the buffer status directly and have their own enable location. Each request line is registered.

The receive flag re-arms by itself. When software clears it while the FIFO still holds messages, the next message moves into the foreground slot and the flag sets again.

Top module: `can_irq_flags`

## Requirements
- R1: After reset the following hold: every flag reads 0, every local enable reads 0, the global mask (bit 7 of location 1) reads 1, both state codes read ok (0), and all four request outputs are low.
- R2: A register write of 8'h?? to location 0 clears exactly the flags whose bits are one. The bits are wake-up (bit 0), status change (bit 1), overrun (bit 2) and receive (bit 3). Zero bits leave their flags unchanged.
- R3: When a flag's set event and its write-one clear fall in the same cycle, the flag ends that cycle set.
- R4: Location 2 bits [2:0] show, one clock after the status, which transmit buffers are empty and unscheduled. Writes to location 2 have no effect on them.
- R5: The receive flag sets on the clock edge at which the end-of-frame strobe is high together with FIFO-not-empty. The strobe alone, with the FIFO empty, does not set it.
- R6: The receive flag sets again one clock after a write-one clear of it if FIFO-not-empty is high on that following clock. If the FIFO is empty, the flag stays clear.
- R7: The wake-up flag sets only on a clock where sleep mode, wake-up enable and bus activity are all high.
- R8: A one-cycle overrun pulse sets the overrun flag.
- R9: Each counter is classified as ok (0) below 96, warning (1) from 96 to 127, and error (2) from 128 to 255. A transmit count of 256 or more is bus-off (3). The transmit code reads in location 0 bits [7:6] and the receive code in bits [5:4], one clock after the count.
- R10: The status-change flag sets on a clock where either counter's range class differs from its stored class, and on no other clock.
- R11: Each request output is high one clock after its flag ANDed with its local enable is high while the global mask is 0. The error request takes status change or overrun. The transmit request takes any empty flag ANDed with its bit in location 3. A set global mask forces all four requests low one clock later.
- R12: Location 1 reads back bits [3:0] as the local enables (same bit order as the flags) and bit 7 as the global mask. Location 3 reads back the transmit enables in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register location |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tx_buf_empty | input | 3 | Per transmit buffer: empty and not scheduled |
| rx_fifo_ne | input | 1 | Receive FIFO foreground slot holds a message |
| rx_eof_ok | input | 1 | End-of-frame strobe of a successfully received message |
| sleep_mode | input | 1 | Controller is in internal sleep |
| wake_en | input | 1 | Wake-up function enabled |
| bus_activity | input | 1 | Activity seen on the bus |
| rx_overrun | input | 1 | One-cycle pulse: message lost to a full FIFO |
| tx_err_cnt | input | 9 | Transmit error counter value |
| rx_err_cnt | input | 8 | Receive error counter value |
| irq_wake | output | 1 | Wake-up request |
| irq_err | output | 1 | Error request |
| irq_rx | output | 1 | Receive request |
| irq_tx | output | 1 | Transmit request |

## Verification
The assertions make three assumptions about the inputs. The overrun input is a single-cycle pulse. FIFO-not-empty stays meaningful on the clock after a receive-flag clear. Register writes arrive as one-cycle strobes. The stimulus drives every input just after a rising edge and holds it for whole cycles. Every write is a single-cycle strobe. Event inputs return to zero on the cycle after each event, so each flag check sees only the event under test. The counter sweeps walk through every transmit and receive count one value per clock and clear the status-change flag on the same clock, so each clock's expected flag depends only on that clock's class transition.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_WARN = 2'd1,
    ST_ERR  = 2'd2,
    ST_BOFF = 2'd3
  } err_state_e;

  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] LOC_FLAGS  = 2'd0;
  localparam logic [REG_AW-1:0] LOC_ENABLE = 2'd1;
  localparam logic [REG_AW-1:0] LOC_TXFLG  = 2'd2;
  localparam logic [REG_AW-1:0] LOC_TXEN   = 2'd3;

  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned EV_WAKE = 0;
  localparam int unsigned EV_CSC  = 1;
  localparam int unsigned EV_OVR  = 2;
  localparam int unsigned EV_RX   = 3;

endpackage

// File: rtl/can_irq_flag.sv
module can_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R3
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R2
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);

  // R2
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/can_err_class.sv
module can_err_class
  import can_irq_pkg::*;
#(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned WARN_LIM = 96,
  parameter int unsigned ERR_LIM  = 128,
  parameter int unsigned BOFF_LIM = 256,
  parameter bit          HAS_BOFF = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output err_state_e       state_o,
  output logic             change_o
);

  logic [31:0] cnt_ext;
  err_state_e  cls_now;
  err_state_e  state_q;
  logic        state_en;

  assign cnt_ext = 32'(cnt_i);

  generate
    if (HAS_BOFF) begin : g_boff
      always_comb begin
        if (cnt_ext >= BOFF_LIM)      cls_now = ST_BOFF;
        else if (cnt_ext >= ERR_LIM)  cls_now = ST_ERR;
        else if (cnt_ext >= WARN_LIM) cls_now = ST_WARN;
        else                          cls_now = ST_OK;
      end
    end else begin : g_no_boff
      always_comb begin
        if (cnt_ext >= ERR_LIM)       cls_now = ST_ERR;
        else if (cnt_ext >= WARN_LIM) cls_now = ST_WARN;
        else                          cls_now = ST_OK;
      end
    end
  endgenerate

  assign change_o = (cls_now != state_q);
  assign state_en = change_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_OK;
    else if (state_en) state_q <= cls_now;
  end

  assign state_o = state_q;

  // R10
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !change_o |=> $stable(state_o));

  // R9
  ok_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ext < WARN_LIM) |=> (state_o == ST_OK));

endmodule

// File: rtl/can_tx_empty.sv
module can_tx_empty #(
  parameter int unsigned NUM_TXBUF = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TXBUF-1:0] empty_i,
  output logic [NUM_TXBUF-1:0] flag_o
);

  logic [NUM_TXBUF-1:0] flag_q;

  for (genvar b = 0; b < NUM_TXBUF; b++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[b] <= 1'b0;
      else         flag_q[b] <= empty_i[b];
    end
  end

  assign flag_o = flag_q;

  // R4
  tx_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_o == $past(empty_i)));

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int unsigned NUM_TXBUF = 3,
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned REC_W     = 8,
  parameter int unsigned WARN_LIM  = 96,
  parameter int unsigned ERR_LIM   = 128,
  parameter int unsigned BOFF_LIM  = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [NUM_TXBUF-1:0] tx_buf_empty,
  input  logic                 rx_fifo_ne,
  input  logic                 rx_eof_ok,
  input  logic                 sleep_mode,
  input  logic                 wake_en,
  input  logic                 bus_activity,
  input  logic                 rx_overrun,
  input  logic [TEC_W-1:0]     tx_err_cnt,
  input  logic [REC_W-1:0]     rx_err_cnt,
  output logic                 irq_wake,
  output logic                 irq_err,
  output logic                 irq_rx,
  output logic                 irq_tx
);

  localparam int unsigned MASK_BIT = REG_DW - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // register decode
  logic wr_flags, wr_enable, wr_txen;
  assign wr_flags  = reg_wr && (reg_addr == LOC_FLAGS);
  assign wr_enable = reg_wr && (reg_addr == LOC_ENABLE);
  assign wr_txen   = reg_wr && (reg_addr == LOC_TXEN);

  // error range classification
  err_state_e tx_state, rx_state;
  logic       tx_chg, rx_chg;

  can_err_class #(
    .CNT_W(TEC_W), .WARN_LIM(WARN_LIM), .ERR_LIM(ERR_LIM),
    .BOFF_LIM(BOFF_LIM), .HAS_BOFF(1'b1)
  ) tx_class_i (
    .clk_i(clk), .rst_ni(rst_s_n), .cnt_i(tx_err_cnt),
    .state_o(tx_state), .change_o(tx_chg)
  );

  can_err_class #(
    .CNT_W(REC_W), .WARN_LIM(WARN_LIM), .ERR_LIM(ERR_LIM),
    .BOFF_LIM(BOFF_LIM), .HAS_BOFF(1'b0)
  ) rx_class_i (
    .clk_i(clk), .rst_ni(rst_s_n), .cnt_i(rx_err_cnt),
    .state_o(rx_state), .change_o(rx_chg)
  );

  // event flags
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_flag;
  logic               rearm_q, rearm_d;

  always_comb begin
    evt_set          = '0;
    evt_set[EV_WAKE] = sleep_mode && wake_en && bus_activity;
    evt_set[EV_CSC]  = tx_chg || rx_chg;
    evt_set[EV_OVR]  = rx_overrun;
    evt_set[EV_RX]   = rx_fifo_ne && (rx_eof_ok || rearm_q);
  end

  assign evt_clr = wr_flags ? reg_wdata[NUM_EVT-1:0] : '0;
  assign rearm_d = evt_clr[EV_RX];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rearm_q <= 1'b0;
    else          rearm_q <= rearm_d;
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    can_irq_flag flag_i (
      .clk_i(clk), .rst_ni(rst_s_n),
      .set_i(evt_set[e]), .clr_i(evt_clr[e]), .flag_o(evt_flag[e])
    );
  end

  // transmit-empty flags
  logic [NUM_TXBUF-1:0] txe_flag;

  can_tx_empty #(.NUM_TXBUF(NUM_TXBUF)) tx_empty_i (
    .clk_i(clk), .rst_ni(rst_s_n), .empty_i(tx_buf_empty), .flag_o(txe_flag)
  );

  // enables and global mask
  logic [NUM_EVT-1:0]   ie_q, ie_d;
  logic                 mask_q, mask_d;
  logic [NUM_TXBUF-1:0] txen_q, txen_d;

  always_comb begin
    ie_d   = ie_q;
    mask_d = mask_q;
    txen_d = txen_q;
    if (wr_enable) begin
      ie_d   = reg_wdata[NUM_EVT-1:0];
      mask_d = reg_wdata[MASK_BIT];
    end
    if (wr_txen) txen_d = reg_wdata[NUM_TXBUF-1:0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ie_q   <= '0;
      mask_q <= 1'b1;
      txen_q <= '0;
    end else begin
      ie_q   <= ie_d;
      mask_q <= mask_d;
      txen_q <= txen_d;
    end
  end

  // request lines
  logic [3:0] irq_d, irq_q;
  logic [NUM_EVT-1:0] evt_on;

  assign evt_on = evt_flag & ie_q;

  always_comb begin
    irq_d[0] = !mask_q && evt_on[EV_WAKE];
    irq_d[1] = !mask_q && (evt_on[EV_CSC] || evt_on[EV_OVR]);
    irq_d[2] = !mask_q && evt_on[EV_RX];
    irq_d[3] = !mask_q && (|(txe_flag & txen_q));
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irq_q <= '0;
    else          irq_q <= irq_d;
  end

  assign irq_wake = irq_q[0];
  assign irq_err  = irq_q[1];
  assign irq_rx   = irq_q[2];
  assign irq_tx   = irq_q[3];

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      LOC_FLAGS:  reg_rdata = {tx_state, rx_state, evt_flag};
      LOC_ENABLE: begin
        reg_rdata[NUM_EVT-1:0] = ie_q;
        reg_rdata[MASK_BIT]    = mask_q;
      end
      LOC_TXFLG:  reg_rdata[NUM_TXBUF-1:0] = txe_flag;
      LOC_TXEN:   reg_rdata[NUM_TXBUF-1:0] = txen_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R11
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mask_q |=> !(irq_wake || irq_err || irq_rx || irq_tx));

  // R11
  rx_req_src_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_rx) |-> $past(evt_flag[EV_RX] && ie_q[EV_RX] && !mask_q));

  // R10
  csc_on_change_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tx_chg || rx_chg) |=> evt_flag[EV_CSC]);

  // R6
  rx_rearm_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rearm_q && rx_fifo_ne) |=> evt_flag[EV_RX]);

  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(evt_flag[EV_WAKE]) |-> $past(sleep_mode && wake_en && bus_activity));

endmodule

// File: tb/can_irq_flags_tb_top.sv
module can_irq_flags_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [2:0] tx_buf_empty;
  logic       rx_fifo_ne, rx_eof_ok, sleep_mode, wake_en, bus_activity, rx_overrun;
  logic [8:0] tx_err_cnt;
  logic [7:0] rx_err_cnt;
  logic       irq_wake, irq_err, irq_rx, irq_tx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  can_irq_flags dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_buf_empty(tx_buf_empty),
    .rx_fifo_ne(rx_fifo_ne), .rx_eof_ok(rx_eof_ok), .sleep_mode(sleep_mode),
    .wake_en(wake_en), .bus_activity(bus_activity), .rx_overrun(rx_overrun),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .irq_wake(irq_wake),
    .irq_err(irq_err), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [1:0] cls(input int v, input bit is_tx);
    if (is_tx && v >= 256) return 2'd3;
    if (v >= 128) return 2'd2;
    if (v >= 96)  return 2'd1;
    return 2'd0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [1:0] prev;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    tx_buf_empty = 3'b000; rx_fifo_ne = 1'b0; rx_eof_ok = 1'b0;
    sleep_mode = 1'b0; wake_en = 1'b0; bus_activity = 1'b0; rx_overrun = 1'b0;
    tx_err_cnt = '0; rx_err_cnt = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    rd(2'd0, d); check("R1 flags", d, 8'h00);
    rd(2'd1, d); check("R1 enables", d, 8'h80);
    rd(2'd2, d); check("R1 txflags", d, 8'h00);
    rd(2'd3, d); check("R1 txen", d, 8'h00);
    check("R1 irqs", {irq_wake, irq_err, irq_rx, irq_tx}, 4'b0000);

    // R12 readback
    wr(2'd1, 8'h8F); rd(2'd1, d); check("R12 enable readback", d, 8'h8F);
    wr(2'd3, 8'h05); rd(2'd3, d); check("R12 txen readback", d, 8'h05);
    wr(2'd1, 8'h00);

    // R4 and R11 transmit: all empty/enable combinations
    for (int e = 0; e < 8; e++) begin
      for (int en = 0; en < 8; en++) begin
        tx_buf_empty = e[2:0];
        wr(2'd3, en[7:0]);
        rd(2'd2, d); check("R4 txe follows status", d, 32'(e));
        step();
        check("R11 tx request", irq_tx, 32'((e & en) != 0));
      end
    end
    tx_buf_empty = 3'b111; step();
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R4 write ignored", d, 8'h07);
    tx_buf_empty = 3'b010; step();
    rd(2'd2, d); check("R4 scheduled clears", d, 8'h02);
    wr(2'd3, 8'h00);

    // R7 wake gating sweep
    for (int v = 0; v < 8; v++) begin
      sleep_mode = v[0]; wake_en = v[1]; bus_activity = v[2];
      step();
      sleep_mode = 1'b0; wake_en = 1'b0; bus_activity = 1'b0;
      rd(2'd0, d); check("R7 wake flag", d[0], 32'(v == 7));
      wr(2'd0, 8'h01);
    end

    // R8 / R2 / R3 overrun
    rx_overrun = 1'b1; step(); rx_overrun = 1'b0;
    rd(2'd0, d); check("R8 overrun sets", d[2], 1);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R2 zero write keeps", d[2], 1);
    wr(2'd0, 8'h04); rd(2'd0, d); check("R2 one write clears", d[2], 0);
    rx_overrun = 1'b1; wr(2'd0, 8'h04); rx_overrun = 1'b0;
    rd(2'd0, d); check("R3 set beats clear", d[2], 1);
    wr(2'd0, 8'h04);

    // R5 / R6 receive
    rx_eof_ok = 1'b1; step(); rx_eof_ok = 1'b0;
    rd(2'd0, d); check("R5 eof with empty fifo", d[3], 0);
    rx_fifo_ne = 1'b1; rx_eof_ok = 1'b1; step(); rx_eof_ok = 1'b0;
    rd(2'd0, d); check("R5 eof sets rx", d[3], 1);
    wr(2'd0, 8'h08); rd(2'd0, d); check("R6 cleared", d[3], 0);
    step(); rd(2'd0, d); check("R6 rearm next message", d[3], 1);
    rx_fifo_ne = 1'b0;
    wr(2'd0, 8'h08); step(); rd(2'd0, d); check("R6 no rearm when empty", d[3], 0);

    // R9 / R10 transmit counter sweep
    prev = 2'd0;
    for (int v = 0; v < 512; v++) begin
      tx_err_cnt = v[8:0];
      wr(2'd0, 8'h02);
      rd(2'd0, d);
      check("R9 tx state", d[7:6], cls(v, 1'b1));
      check("R10 tx status change", d[1], 32'(cls(v, 1'b1) != prev));
      prev = cls(v, 1'b1);
    end
    tx_err_cnt = '0; wr(2'd0, 8'h02); wr(2'd0, 8'h02);
    rd(2'd0, d); check("R10 no change holds clear", d[1], 0);

    // R9 / R10 receive counter sweep
    prev = 2'd0;
    for (int v = 0; v < 256; v++) begin
      rx_err_cnt = v[7:0];
      wr(2'd0, 8'h02);
      rd(2'd0, d);
      check("R9 rx state", d[5:4], cls(v, 1'b0));
      check("R10 rx status change", d[1], 32'(cls(v, 1'b0) != prev));
      prev = cls(v, 1'b0);
    end
    rx_err_cnt = '0; wr(2'd0, 8'h02); wr(2'd0, 8'h02);

    // R11 error request and global mask
    wr(2'd1, 8'h02);
    tx_err_cnt = 9'd100; step();
    check("R11 err latency", irq_err, 0);
    step(); check("R11 err request", irq_err, 1);
    wr(2'd1, 8'h82); step(); check("R11 mask blocks", irq_err, 0);
    wr(2'd0, 8'h02); wr(2'd1, 8'h04);
    rx_overrun = 1'b1; step(); rx_overrun = 1'b0; step();
    check("R11 overrun request", irq_err, 1);
    wr(2'd0, 8'h04);

    // R11 receive and wake requests
    wr(2'd1, 8'h08);
    rx_fifo_ne = 1'b1; rx_eof_ok = 1'b1; step(); rx_eof_ok = 1'b0; rx_fifo_ne = 1'b0;
    step(); check("R11 rx request", irq_rx, 1);
    wr(2'd1, 8'h01);
    sleep_mode = 1'b1; wake_en = 1'b1; bus_activity = 1'b1; step();
    sleep_mode = 1'b0; wake_en = 1'b0; bus_activity = 1'b0;
    step(); check("R11 wake request", irq_wake, 1);
    check("R11 rx disabled", irq_rx, 0);

    finish_run();
  end

endmodule